// File: doc/BRIEF.md
# Return Address Stack

This block keeps subroutine return addresses in a private store, apart from the general registers and data memory. A call strobe pushes the address of the instruction that follows the call, which is the current program counter plus one. A return strobe hands back the most recent address so that the program counter can take it, and then discards that entry.

The stack grows upward from entry 0. The pointer always names the next free slot, so the top entry is the one just below it. The return address output is a combinational read of that top entry. During the cycle in which the return strobe is high, the output already holds the address to be returned to. The program counter can therefore load it on the same edge that pops the entry.

There is no overflow or underflow detection. The pointer wraps around the storage size, and entries already written persist across reset.

Top module: `ras_stack`

## Requirements
- R1: A synchronous active-high reset sets the pointer to 0, so the first call after reset writes entry 0. Storage contents are not cleared by reset.
- R2: A clock edge with the call strobe high writes the program counter input plus one into the entry the pointer names, then advances the pointer by one. Right after that edge, the return address output shows the value just written.
- R3: While the return strobe is high, and before the clock edge, the return address output equals the entry at pointer minus one. That edge lowers the pointer by one, and afterwards the output shows the entry below the popped one.
- R4: A clock edge with both strobes low leaves the pointer and the storage unchanged. The output therefore stays stable even when the program counter input changes.
- R5: Nested calls followed by the same number of returns give back the pushed addresses in last-in, first-out order.
- R6: The pushed value is the program counter plus one, truncated to 16 bits, so a call at 16'hFFFF pushes 16'h0000.
- R7: The pointer wraps from 255 to 0 on a call. The 257th consecutive push after reset overwrites entry 0, and the following return yields that new value.
- R8: The pointer wraps from 0 to 255 on a return. A return at pointer 0 presents entry 255, and afterwards the output shows entry 254.
- R9: The call and return strobes are never high on the same clock edge. This is an input contract that the checker watches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the pointer |
| call_i | input | 1 | Push strobe for a call instruction |
| ret_i | input | 1 | Pop strobe for a return instruction |
| pc_i | input | 16 | Current program counter |
| ret_addr_o | output | 16 | Entry at pointer minus one (top of stack) |

## Verification
A push has effect one rising edge later, so the bench drives a call at a falling edge and reads the output just after the next rising edge. A return's result is due with no delay: the bench reads the output shortly after driving the strobe and before the edge. It then reads again after the edge to see the effect of the lowered pointer. Idle steps are sampled after the edge, so any unwanted change to the pointer or storage would show on the output.

// File: rtl/ras_pkg.sv
package ras_pkg;

    localparam int RAS_PC_W  = 16;
    localparam int RAS_PTR_W = 8;

    typedef enum logic [1:0] {
        RAS_HOLD = 2'd0,
        RAS_PUSH = 2'd1,
        RAS_POP  = 2'd2
    } ras_op_e;

    // Strobe decode; push wins if the contract of exclusive strobes is broken.
    function automatic ras_op_e ras_decode(input logic call_s, input logic ret_s);
        if (call_s)      return RAS_PUSH;
        else if (ret_s)  return RAS_POP;
        else             return RAS_HOLD;
    endfunction

endpackage

// File: rtl/ras_cmd.sv
module ras_cmd
    import ras_pkg::*;
#(
    parameter int PC_W = RAS_PC_W
) (
    input  logic            call_i,
    input  logic            ret_i,
    input  logic [PC_W-1:0] pc_i,
    output ras_op_e         op_o,
    output logic            wr_en_o,
    output logic [PC_W-1:0] wr_data_o
);

    localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

    always_comb begin
        op_o      = ras_decode(call_i, ret_i);
        wr_en_o   = (op_o == RAS_PUSH);
        wr_data_o = pc_i + ONE;   // address of the instruction after the call
    end

endmodule

// File: rtl/ras_ptr.sv
module ras_ptr
    import ras_pkg::*;
#(
    parameter int PTR_W = RAS_PTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  ras_op_e          op_i,
    output logic [PTR_W-1:0] sp_o,
    output logic [PTR_W-1:0] top_o
);

    localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] sp_d;

    always_comb begin
        unique case (op_i)
            RAS_PUSH: sp_d = sp_q + ONE;
            RAS_POP:  sp_d = sp_q - ONE;
            default:  sp_d = sp_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sp_q <= '0;
        else     sp_q <= sp_d;
    end

    assign sp_o  = sp_q;
    assign top_o = sp_q - ONE;

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int PTR_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PTR_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/ras_stack.sv
module ras_stack
    import ras_pkg::*;
#(
    parameter int PC_W  = RAS_PC_W,
    parameter int PTR_W = RAS_PTR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] ret_addr_o
);

    ras_op_e          op;
    logic             wr_en;
    logic [PC_W-1:0]  wr_data;
    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] top_idx;

    ras_cmd #(.PC_W(PC_W)) u_cmd (
        .call_i   (call_i),
        .ret_i    (ret_i),
        .pc_i     (pc_i),
        .op_o     (op),
        .wr_en_o  (wr_en),
        .wr_data_o(wr_data)
    );

    ras_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .op_i (op),
        .sp_o (sp_q),
        .top_o(top_idx)
    );

    ras_store #(.PTR_W(PTR_W), .DATA_W(PC_W)) u_store (
        .clk    (clk),
        .we_i   (wr_en),
        .waddr_i(sp_q),
        .wdata_i(wr_data),
        .raddr_i(top_idx),
        .rdata_o(ret_addr_o)
    );

endmodule

// File: rtl/ras_stack_chk.sv
module ras_stack_chk #(
    parameter int PC_W  = 16,
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             call_i,
    input logic             ret_i,
    input logic [PC_W-1:0]  pc_i,
    input logic [PC_W-1:0]  ret_addr_o,
    input logic [PTR_W-1:0] sp
);

    localparam logic [PTR_W-1:0] P1 = {{(PTR_W-1){1'b0}}, 1'b1};
    localparam logic [PC_W-1:0]  A1 = {{(PC_W-1){1'b0}}, 1'b1};

    assert_reset_ptr_R1: assert property (@(posedge clk)
        rst |=> (sp == '0));

    assert_push_value_R2: assert property (@(posedge clk) disable iff (rst)
        call_i |=> (ret_addr_o == $past(pc_i) + A1));

    assert_push_ptr_R7: assert property (@(posedge clk) disable iff (rst)
        call_i |=> (sp == $past(sp) + P1));

    assert_pop_ptr_R8: assert property (@(posedge clk) disable iff (rst)
        ret_i |=> (sp == $past(sp) - P1));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!call_i && !ret_i) |=> ($stable(sp) && $stable(ret_addr_o)));

    assert_excl_strobes_R9: assert property (@(posedge clk) disable iff (rst)
        !(call_i && ret_i));

endmodule

bind ras_stack ras_stack_chk #(.PC_W(PC_W), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .pc_i      (pc_i),
    .ret_addr_o(ret_addr_o),
    .sp        (sp_q)
);

// File: tb/ras_stack_test.sv
module ras_stack_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 10;

    typedef struct packed {
        logic        c;
        logic        r;
        logic [15:0] pc;
        logic [15:0] exp;
    } vec_t;

    // call/idle: exp is the output after the edge; ret: exp is the output before it
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 16'h0010, 16'h0011},
        '{1'b1, 1'b0, 16'h0100, 16'h0101},
        '{1'b0, 1'b0, 16'h7777, 16'h0101},
        '{1'b1, 1'b0, 16'h2000, 16'h2001},
        '{1'b0, 1'b1, 16'h2001, 16'h2001},
        '{1'b0, 1'b1, 16'h0101, 16'h0101},
        '{1'b1, 1'b0, 16'hFFFF, 16'h0000},
        '{1'b0, 1'b0, 16'h1234, 16'h0000},
        '{1'b0, 1'b1, 16'h0000, 16'h0000},
        '{1'b0, 1'b1, 16'h0011, 16'h0011}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_i = 1'b0;
    logic        ret_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [15:0] ret_addr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ras_stack uut (
        .clk       (clk),
        .rst       (rst),
        .call_i    (call_i),
        .ret_i     (ret_i),
        .pc_i      (pc_i),
        .ret_addr_o(ret_addr_o)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: ret_addr_o=%h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; call_i = 1'b0; ret_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // drive at the falling edge, hold through one rising edge
    task automatic push(input logic [15:0] pc);
        @(negedge clk);
        call_i = 1'b1; ret_i = 1'b0; pc_i = pc;
        @(posedge clk); #1;
        call_i = 1'b0;
    endtask

    task automatic pop(input string req, input logic [15:0] exp_before);
        @(negedge clk);
        call_i = 1'b0; ret_i = 1'b1;
        #1 check(req, ret_addr_o, exp_before);
        @(posedge clk); #1;
        ret_i = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();

        // table walk: nested calls, idle, LIFO returns, 16-bit increment wrap
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            call_i = VECS[i].c; ret_i = VECS[i].r; pc_i = VECS[i].pc;
            if (VECS[i].r) begin
                #1 check("R3/R5 return value", ret_addr_o, VECS[i].exp);
                @(posedge clk); #1;
            end else begin
                @(posedge clk); #1;
                if (VECS[i].c) check("R2/R6 push value", ret_addr_o, VECS[i].exp);
                else           check("R4 idle hold", ret_addr_o, VECS[i].exp);
            end
            call_i = 1'b0; ret_i = 1'b0;
        end

        // R1: reset returns pointer to 0; new pushes overwrite entry 0 and 1
        push(16'h0A00);
        push(16'h0B00);
        do_reset();
        push(16'h0300);
        check("R1 push after reset", ret_addr_o, 16'h0301);
        push(16'h0400);
        pop("R1 second entry", 16'h0401);
        #1 check("R1 entry 0 after pop", ret_addr_o, 16'h0301);
        pop("R1 entry 0 pop", 16'h0301);

        // R7: fill all 256 entries, then one more push wraps to entry 0
        do_reset();
        for (int i = 0; i < 256; i++) push(16'(i * 3));
        check("R7 last of 256 pushes", ret_addr_o, 16'd766);
        push(16'hABCD);
        check("R7 wrapped push at entry 0", ret_addr_o, 16'hABCE);
        pop("R7 pop wrapped entry", 16'hABCE);
        #1 check("R7 entry 255 after pop", ret_addr_o, 16'd766);

        // R8: from pointer 0, a return reads entry 255 and leaves 254 on top
        do_reset();
        pop("R8 underflow reads entry 255", 16'd766);
        #1 check("R8 entry 254 after underflow", ret_addr_o, 16'd763);

        // R4: idle cycles with a changing PC leave the top intact
        @(negedge clk);
        pc_i = 16'h5555;
        @(posedge clk); #1;
        check("R4 idle with PC change", ret_addr_o, 16'd763);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule